// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block contains two counting channels. Each channel has a count split into a low byte and a high byte. One shared configuration byte selects, per channel, whether the channel times or counts, whether a hardware gate pin takes part in enabling it, and which of four counting layouts it uses. A control byte holds a run bit and an overflow flag for each channel. The layouts are a 13-bit count with a 5-bit prescaler, a full 16-bit count, an 8-bit count that reloads itself, and a split layout.

In timer operation a channel advances once for each cycle in which `tick` is high. `tick` is the machine-cycle strobe, pulsed once every twelve oscillator periods. In counter operation the channel's external pin is sampled on each tick, and every high-to-low change between two successive samples advances the count by one.

Overflow flags are visible on `ovf_flag`. Software reads and writes them through the control byte. A pulse on `irq_ack` clears a flag when its interrupt is taken.

Top module: `tmr_pair`

## Requirements
- R1: After synchronous reset, all registers read 0, `ovf_flag` is 0 and `rdata` is 0.
- R2: Register map on `addr`:
  - 0 is the configuration byte. Bits 3:0 belong to channel 0 and bits 7:4 to channel 1. Within a nibble, bit 3 is gate enable, bit 2 is counter select, and bits 1:0 are the mode.
  - 1 is the control byte: bit 7 is the channel 1 flag, bit 6 the channel 1 run bit, bit 5 the channel 0 flag and bit 4 the channel 0 run bit. Bits 3:0 read 0 and ignore writes.
  - 2 and 3 are the channel 0 low and high bytes; 4 and 5 are the channel 1 low and high bytes.
  - `rdata` shows the addressed register one clock after `addr` is presented.
- R3: With counter select 0, an enabled channel advances by exactly one per cycle with `tick` high, and holds in cycles without `tick`.
- R4: With counter select 1, the channel's `cnt_pin` is sampled on each tick. The count advances by one only when the previous sample was 1 and the current one is 0. The sample register resets to 0.
- R5: A channel is enabled only when its run bit is 1 and either its gate enable is 0 or its `gate_pin` is high.
- R6: Mode 0 (13-bit): low bits 4:0 form a prescaler whose carry advances the high byte. Low bits 7:5 are unchanged by counting. Advancing from 1FFFh wraps to zero and sets the flag.
- R7: Mode 1 (16-bit): the count advances from FFFFh to 0000h and sets the flag.
- R8: Mode 2 (auto-reload): only the low byte counts. Advancing from FFh loads the low byte from the high byte and sets the flag.
- R9: Split mode on channel 0 (mode 3):
  - The channel 0 low byte counts under channel 0's own controls and sets the channel 0 flag on wrapping.
  - The channel 0 high byte counts ticks while the channel 1 run bit is 1 and sets the channel 1 flag on wrapping.
  - Channel 1 then ignores its run bit (its gate still applies), and its overflows set no flag.
- R10: Channel 1 in mode 3 holds its count.
- R11: A high `irq_ack[i]` clears flag i. An overflow in the same cycle wins over both the acknowledge and a software write. Software writes to the control byte set or clear the flags.
- R12: `ovf_flag[i]` follows flag i with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Machine-cycle strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| cnt_pin | input | 2 | External count inputs, one per channel |
| gate_pin | input | 2 | Hardware gate inputs, one per channel |
| irq_ack | input | 2 | Interrupt acknowledge, clears matching flag |
| ovf_flag | output | 2 | Overflow flags |

## Verification
The assertions check, on every cycle, several hold conditions:
- counts hold when there is no tick, when the run bit is off, and when the gate pin is low;
- channel 1 holds in mode 3;
- an acknowledge clears a flag;
- channel 1 never raises its flag by itself while split.

The counting arithmetic needs the bench's scenarios. That covers prescaler carry, wrap values, reload contents, falling-edge counting, the borrowed run bit in split mode and the overflow-over-acknowledge priority. The bench compares them against a reference stepping function, using random start values near the wrap points.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BW    = 8;
  localparam int PRE_W = 5;
  localparam int AW    = 3;
  localparam int NCH   = 2;

  typedef enum logic [1:0] {
    MD_13B   = 2'd0,
    MD_16B   = 2'd1,
    MD_8AR   = 2'd2,
    MD_SPLIT = 2'd3
  } tmode_e;

  typedef struct packed {
    logic   gate;
    logic   ext;
    tmode_e mode;
  } chcfg_t;
endpackage

// File: rtl/tmr_fall.sv
module tmr_fall (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pin,
  output logic fall
);
  logic smp_q;

  always_ff @(posedge clk) begin
    if (rst)       smp_q <= 1'b0;
    else if (tick) smp_q <= pin;
  end

  assign fall = tick & smp_q & ~pin;

  // R4: a counted edge leaves a low sample behind
  a_r4_fall_leaves_low: assert property (@(posedge clk) disable iff (rst)
    fall |=> !smp_q);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan import tmr_pkg::*; #(
  parameter int DW  = 8,
  parameter int PRE = 5
) (
  input  tmode_e        mode,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  input  logic          inc_lo,
  input  logic          inc_hi,
  output logic [DW-1:0] lo_nx,
  output logic [DW-1:0] hi_nx,
  output logic          ovf_lo,
  output logic          ovf_hi
);
  localparam logic [DW-1:0]  ONES = '1;
  localparam logic [PRE-1:0] PMAX = '1;

  always_comb begin
    lo_nx  = lo;
    hi_nx  = hi;
    ovf_lo = 1'b0;
    ovf_hi = 1'b0;
    case (mode)
      MD_13B: if (inc_lo) begin
        lo_nx[PRE-1:0] = lo[PRE-1:0] + 1'b1;
        if (lo[PRE-1:0] == PMAX) begin
          hi_nx  = hi + 1'b1;
          ovf_lo = (hi == ONES);
        end
      end
      MD_16B: if (inc_lo) begin
        lo_nx = lo + 1'b1;
        if (lo == ONES) begin
          hi_nx  = hi + 1'b1;
          ovf_lo = (hi == ONES);
        end
      end
      MD_8AR: if (inc_lo) begin
        if (lo == ONES) begin
          lo_nx  = hi;
          ovf_lo = 1'b1;
        end else begin
          lo_nx = lo + 1'b1;
        end
      end
      default: begin
        if (inc_lo) begin
          lo_nx  = lo + 1'b1;
          ovf_lo = (lo == ONES);
        end
        if (inc_hi) begin
          hi_nx  = hi + 1'b1;
          ovf_hi = (hi == ONES);
        end
      end
    endcase
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair import tmr_pkg::*; #(
  parameter int DW   = tmr_pkg::BW,
  parameter int AW_P = tmr_pkg::AW,
  parameter int PRE  = tmr_pkg::PRE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            wr_en,
  input  logic [AW_P-1:0] addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [1:0]      cnt_pin,
  input  logic [1:0]      gate_pin,
  input  logic [1:0]      irq_ack,
  output logic [1:0]      ovf_flag
);
  localparam logic [AW_P-1:0] A_MODE = AW_P'(0);
  localparam logic [AW_P-1:0] A_CTRL = AW_P'(1);
  localparam logic [AW_P-1:0] A_LO0  = AW_P'(2);
  localparam logic [AW_P-1:0] A_HI0  = AW_P'(3);
  localparam logic [AW_P-1:0] A_LO1  = AW_P'(4);
  localparam logic [AW_P-1:0] A_HI1  = AW_P'(5);

  logic [DW-1:0] mode_q;
  logic [1:0]    tr_q, tf_q;
  logic [DW-1:0] lo_q [NCH];
  logic [DW-1:0] hi_q [NCH];
  logic [DW-1:0] lo_nx [NCH];
  logic [DW-1:0] hi_nx [NCH];
  chcfg_t        cfg [NCH];
  logic [1:0]    fall, ev, run_eff, en, inc_lo, inc_hi, ovf_lo, ovf_hi, set_f;
  logic          split, wr_ctrl, wr_cnt0, wr_cnt1;

  assign split   = (cfg[0].mode == MD_SPLIT);
  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_cnt0 = wr_en && (addr == A_LO0 || addr == A_HI0);
  assign wr_cnt1 = wr_en && (addr == A_LO1 || addr == A_HI1);

  // run bit of channel 1 is borrowed by channel 0's high byte in split mode
  assign run_eff[0] = tr_q[0];
  assign run_eff[1] = split | tr_q[1];
  assign inc_lo[0]  = ev[0] & en[0];
  assign inc_lo[1]  = ev[1] & en[1] & (cfg[1].mode != MD_SPLIT);
  assign inc_hi[0]  = split & tick & tr_q[1];
  assign inc_hi[1]  = 1'b0;
  assign set_f[0]   = ovf_lo[0];
  assign set_f[1]   = split ? ovf_hi[0] : ovf_lo[1];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cfg[i] = mode_q[4*i +: 4];

    tmr_fall u_fall (
      .clk (clk), .rst (rst), .tick (tick), .pin (cnt_pin[i]), .fall (fall[i])
    );

    assign ev[i] = cfg[i].ext ? fall[i] : tick;
    assign en[i] = run_eff[i] & (~cfg[i].gate | gate_pin[i]);

    tmr_chan #(.DW(DW), .PRE(PRE)) u_chan (
      .mode   (cfg[i].mode),
      .lo     (lo_q[i]),
      .hi     (hi_q[i]),
      .inc_lo (inc_lo[i]),
      .inc_hi (inc_hi[i]),
      .lo_nx  (lo_nx[i]),
      .hi_nx  (hi_nx[i]),
      .ovf_lo (ovf_lo[i]),
      .ovf_hi (ovf_hi[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      tr_q   <= '0;
      tf_q   <= '0;
      for (int i = 0; i < NCH; i++) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end
    end else begin
      if (wr_en && addr == A_MODE) mode_q <= wdata;
      for (int i = 0; i < NCH; i++) begin
        if (wr_ctrl) tr_q[i] <= wdata[4+2*i];
        if (set_f[i])        tf_q[i] <= 1'b1;
        else if (irq_ack[i]) tf_q[i] <= 1'b0;
        else if (wr_ctrl)    tf_q[i] <= wdata[5+2*i];
        if (wr_en && addr == AW_P'(2+2*i)) lo_q[i] <= wdata;
        else                               lo_q[i] <= lo_nx[i];
        if (wr_en && addr == AW_P'(3+2*i)) hi_q[i] <= wdata;
        else                               hi_q[i] <= hi_nx[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        A_MODE:  rdata <= mode_q;
        A_CTRL:  rdata <= DW'({tf_q[1], tr_q[1], tf_q[0], tr_q[0], 4'b0000});
        A_LO0:   rdata <= lo_q[0];
        A_HI0:   rdata <= hi_q[0];
        A_LO1:   rdata <= lo_q[1];
        A_HI1:   rdata <= hi_q[1];
        default: rdata <= '0;
      endcase
    end
  end

  assign ovf_flag = tf_q;

  // R3: nothing advances without a tick
  a_r3_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_cnt0) |=> ($stable(lo_q[0]) && $stable(hi_q[0])));
  // R5: run bit off stops channel 0
  a_r5_run_off_hold: assert property (@(posedge clk) disable iff (rst)
    (!tr_q[0] && !split && !wr_cnt0) |=> ($stable(lo_q[0]) && $stable(hi_q[0])));
  // R5: gate enabled with gate pin low stops channel 0
  a_r5_gate_low_hold: assert property (@(posedge clk) disable iff (rst)
    (cfg[0].gate && !gate_pin[0] && !split && !wr_cnt0)
      |=> ($stable(lo_q[0]) && $stable(hi_q[0])));
  // R10: channel 1 in mode 3 is frozen
  a_r10_ch1_frozen: assert property (@(posedge clk) disable iff (rst)
    (cfg[1].mode == MD_SPLIT && !wr_cnt1) |=> ($stable(lo_q[1]) && $stable(hi_q[1])));
  // R11: acknowledge clears the flag when no overflow can occur
  a_r11_ack_clear0: assert property (@(posedge clk) disable iff (rst)
    (irq_ack[0] && !tick && !wr_ctrl) |=> !tf_q[0]);
  a_r11_ack_clear1: assert property (@(posedge clk) disable iff (rst)
    (irq_ack[1] && !tick && !wr_ctrl) |=> !tf_q[1]);
  // R9: in split mode, channel 1's flag rises only via the borrowed high byte
  a_r9_split_flag1: assert property (@(posedge clk) disable iff (rst)
    (split && !tf_q[1] && !wr_ctrl && !(tr_q[1] && tick)) |=> !tf_q[1]);
endmodule

// File: tb/tb_tmr_pair.sv
module tb_tmr_pair;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] cnt_pin = '0;
  logic [1:0] gate_pin = '0;
  logic [1:0] irq_ack = '0;
  logic [1:0] ovf_flag;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  tmr_pair dut (
    .clk (clk), .rst (rst), .tick (tick), .wr_en (wr_en), .addr (addr),
    .wdata (wdata), .rdata (rdata), .cnt_pin (cnt_pin), .gate_pin (gate_pin),
    .irq_ack (irq_ack), .ovf_flag (ovf_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic tickp(input logic p);
    @(negedge clk); cnt_pin[0] = p; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  // reference stepping: returns {flag, hi, lo}
  function automatic logic [16:0] adv(input logic [1:0] m, input logic [7:0] lo,
                                      input logic [7:0] hi, input int n);
    logic        f;
    logic [12:0] v;
    f = 1'b0;
    for (int k = 0; k < n; k++) begin
      case (m)
        2'd0: begin
          v = {hi, lo[4:0]};
          if (v == 13'h1FFF) f = 1'b1;
          v = v + 13'd1;
          hi = v[12:5];
          lo = {lo[7:5], v[4:0]};
        end
        2'd1: begin
          if ({hi, lo} == 16'hFFFF) f = 1'b1;
          {hi, lo} = {hi, lo} + 16'd1;
        end
        default: begin
          if (lo == 8'hFF) begin lo = hi; f = 1'b1; end
          else lo = lo + 8'd1;
        end
      endcase
    end
    return {f, hi, lo};
  endfunction

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [16:0] e;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); chk("R1 reset reg", v, 0);
    end
    chk("R1 reset flags", ovf_flag, 0);

    // R2 map, R12 flag output
    wr(3'd2, 8'h12); rd(3'd2, v); chk("R2 low0 rw", v, 8'h12);
    wr(3'd0, 8'hA5); rd(3'd0, v); chk("R2 cfg rw", v, 8'hA5);
    wr(3'd1, 8'hFF); rd(3'd1, v); chk("R2 ctrl low bits zero", v, 8'hF0);
    chk("R12 flags visible", ovf_flag, 2'b11);
    wr(3'd1, 8'h00); chk("R12 flags cleared by write", ovf_flag, 2'b00);

    // R3 / R7: 16-bit wrap
    wr(3'd0, 8'h01); wr(3'd2, 8'hFD); wr(3'd3, 8'hFF); wr(3'd1, 8'h10);
    repeat (5) @(negedge clk);
    rd(3'd2, v); chk("R3 no tick hold", v, 8'hFD);
    ticks(3);
    rd(3'd2, v); chk("R7 wrap low", v, 8'h00);
    rd(3'd3, v); chk("R7 wrap high", v, 8'h00);
    chk("R7 flag", ovf_flag[0], 1'b1);
    @(negedge clk); irq_ack = 2'b01; @(negedge clk); irq_ack = 2'b00;
    chk("R11 ack clears", ovf_flag[0], 1'b0);

    // R6: 13-bit prescaler wrap, upper low bits kept
    wr(3'd0, 8'h00); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    ticks(2);
    rd(3'd2, v); chk("R6 low", v, 8'hE0);
    rd(3'd3, v); chk("R6 high", v, 8'h00);
    chk("R6 flag", ovf_flag[0], 1'b1);
    wr(3'd1, 8'h10);

    // R8: auto reload
    wr(3'd0, 8'h02); wr(3'd3, 8'h80); wr(3'd2, 8'hFE);
    ticks(2);
    rd(3'd2, v); chk("R8 reload low", v, 8'h80);
    rd(3'd3, v); chk("R8 high kept", v, 8'h80);
    chk("R8 flag", ovf_flag[0], 1'b1);

    // R5: run bit and gate
    wr(3'd0, 8'h01); wr(3'd1, 8'h00); wr(3'd3, 8'h00); wr(3'd2, 8'h07);
    ticks(2); rd(3'd2, v); chk("R5 run off", v, 8'h07);
    wr(3'd1, 8'h10); gate_pin[0] = 1'b0;
    ticks(1); rd(3'd2, v); chk("R5 gate disabled ignores pin", v, 8'h08);
    wr(3'd0, 8'h09);
    ticks(1); rd(3'd2, v); chk("R5 gate pin low", v, 8'h08);
    gate_pin[0] = 1'b1;
    ticks(1); rd(3'd2, v); chk("R5 gate pin high", v, 8'h09);

    // R4: falling edges between tick samples
    wr(3'd0, 8'h05); wr(3'd2, 8'h00);
    tickp(1'b1); tickp(1'b0); tickp(1'b0); tickp(1'b1); tickp(1'b0);
    rd(3'd2, v); chk("R4 edge count", v, 8'h02);
    @(negedge clk); cnt_pin[0] = 1'b1; repeat (3) @(negedge clk);
    rd(3'd2, v); chk("R4 no sample without tick", v, 8'h02);
    tickp(1'b1);

    // R11: overflow wins over acknowledge
    wr(3'd0, 8'h01); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd1, 8'h10);
    @(negedge clk); tick = 1'b1; irq_ack = 2'b01;
    @(negedge clk); tick = 1'b0; irq_ack = 2'b00;
    chk("R11 overflow beats ack", ovf_flag[0], 1'b1);

    // R9: split mode
    wr(3'd0, 8'h13); wr(3'd1, 8'h50);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd4, 8'h10); wr(3'd5, 8'h00);
    ticks(1);
    rd(3'd2, v); chk("R9 split low0", v, 8'h00);
    rd(3'd3, v); chk("R9 split high0", v, 8'h00);
    rd(3'd4, v); chk("R9 ch1 counts", v, 8'h11);
    chk("R9 both flags", ovf_flag, 2'b11);
    wr(3'd1, 8'h10);
    ticks(1);
    rd(3'd3, v); chk("R9 high0 needs run1", v, 8'h00);
    rd(3'd2, v); chk("R9 low0 runs", v, 8'h01);
    rd(3'd4, v); chk("R9 ch1 ignores run bit", v, 8'h12);
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    ticks(1);
    rd(3'd4, v); chk("R9 ch1 wraps", v, 8'h00);
    chk("R9 ch1 no flag", ovf_flag, 2'b00);

    // R10: channel 1 mode 3 frozen
    wr(3'd0, 8'h30); wr(3'd1, 8'h40); wr(3'd4, 8'h05);
    ticks(3);
    rd(3'd4, v); chk("R10 ch1 frozen", v, 8'h05);
    chk("R10 no flag", ovf_flag[1], 1'b0);

    // random scenarios for R6 R7 R8
    for (int it = 0; it < 24; it++) begin
      logic [1:0] m;
      logic [7:0] lo, hi;
      int n;
      string tag;
      m  = 2'($urandom % 3);
      lo = 8'($urandom); hi = 8'($urandom);
      if ($urandom % 2) begin hi = 8'hFF; lo = 8'hF0 | 8'($urandom % 16); end
      n  = 1 + int'($urandom % 60);
      tag = (m == 0) ? "R6 random" : (m == 1) ? "R7 random" : "R8 random";
      wr(3'd0, {6'b0, m}); wr(3'd1, 8'h10); wr(3'd2, lo); wr(3'd3, hi);
      ticks(n);
      e = adv(m, lo, hi, n);
      rd(3'd2, v); chk(tag, v, e[7:0]);
      rd(3'd3, v); chk(tag, v, e[15:8]);
      chk(tag, ovf_flag[0], e[16]);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule